// File: doc/BRIEF.md
# Masked General-Purpose I/O Port

This block is a 32-pin general-purpose I/O port that sits on a simple word-wide register bus. Software configures each pin as an input or an output and drives output levels. It also samples the level on every pad. Output levels change through a whole-word load or through dedicated set and clear words, so one store changes only the chosen pins, with no read-modify-write.

A mask word limits every access that touches pin levels. A pin whose mask bit is 1 reads as zero in the pin-level word and cannot be changed by a load, set or clear. Drivers can therefore own disjoint groups of pins without disturbing each other. The pad inputs pass through a two-stage synchronizer before they can be read. Read data is registered and appears on the cycle after the read strobe.

Top module: `mgpio_port`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, direction, mask and output latch are all zero. `padOe`, `padOut` and `busRdData` are zero.
- R2: Word index 0 holds the direction bits; it reads back what was written; `padOe` bit i equals direction bit i, where 1 means output.
- R3: Word index 4 holds the mask bits and reads back what was written; a mask bit of 1 blocks the matching pin and a mask bit of 0 enables it.
- R4: A read of word index 5 returns the synchronized pad level ANDed with the inverted mask, whatever the direction bits are. A pad level held from edge k onward is seen by a read strobe sampled at edge k+2 or later.
- R5: A write to word index 5 copies the written bits into the output latch where the mask bit is 0; latch bits under a mask bit of 1 keep their value.
- R6: A write to word index 6 sets each latch bit whose written bit is 1 and whose mask bit is 0; all other latch bits are unchanged.
- R7: A read of word index 6 returns the whole output latch, regardless of the mask.
- R8: A write to word index 7 clears each latch bit whose written bit is 1 and whose mask bit is 0; all other latch bits are unchanged; a read of word index 7 returns zero.
- R9: A read of word index 1, 2 or 3 returns zero, and a write to any of them changes no state.
- R10: `padOut` bit i equals output latch bit i at all times.
- R11: `busRdData` is updated on the clock edge that samples `busRdEn`. It holds the selected word for one cycle and is zero in every cycle whose preceding edge saw no read strobe. A write in the same cycle as a read does not affect that read's data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe for the addressed word |
| busRdEn | input | 1 | Read strobe for the addressed word |
| busAddr | input | 3 | Word index (byte offset divided by four) |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data |
| padIn | input | 32 | Levels sampled from the pads |
| padOut | output | 32 | Levels driven to the pads |
| padOe | output | 32 | Per-pad output enable |

## Verification
A corrupted direction or output latch bit shows on `padOe` or `padOut` one cycle after the edge that corrupted it, so comparing those ports on every cycle catches it at once. A wrong mask bit can stay hidden until a later pin read, load, set or clear touches that pin. The bench therefore issues many random mask values followed by pin accesses, and the error then shows as a stray or missing bit on `busRdData` or `padOut` a cycle later. Synchronizer faults show as wrong pin-read data two cycles after a pad change.

// File: rtl/mgpio_pkg.sv
package mgpio_pkg;

  localparam logic [2:0] WIDX_DIR  = 3'd0;
  localparam logic [2:0] WIDX_MASK = 3'd4;
  localparam logic [2:0] WIDX_PIN  = 3'd5;
  localparam logic [2:0] WIDX_SET  = 3'd6;
  localparam logic [2:0] WIDX_CLR  = 3'd7;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_ZERO,
    RD_DIR,
    RD_MASK,
    RD_PIN,
    RD_LATCH
  } rdSel_e;

  typedef struct packed {
    logic   dirWr;
    logic   maskWr;
    logic   pinWr;
    logic   setWr;
    logic   clrWr;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/mgpio_ctrl.sv
module mgpio_ctrl #(
  parameter int ADDR_W = 3
) (
  input  logic                  busWrEn,
  input  logic                  busRdEn,
  input  logic [ADDR_W-1:0]     busAddr,
  output mgpio_pkg::strobe_t    strb
);
  import mgpio_pkg::*;

  localparam int IDX_W = 3;

  logic             upperZero;
  logic [IDX_W-1:0] wordIdx;

  assign wordIdx = busAddr[IDX_W-1:0];

  generate
    if (ADDR_W > IDX_W) begin : gUpper
      assign upperZero = (busAddr[ADDR_W-1:IDX_W] == '0);
    end else begin : gNoUpper
      assign upperZero = 1'b1;
    end
  endgenerate

  always_comb begin
    strb = '0;
    strb.rdSel = RD_NONE;
    if (busWrEn && upperZero) begin
      unique case (wordIdx)
        WIDX_DIR:  strb.dirWr  = 1'b1;
        WIDX_MASK: strb.maskWr = 1'b1;
        WIDX_PIN:  strb.pinWr  = 1'b1;
        WIDX_SET:  strb.setWr  = 1'b1;
        WIDX_CLR:  strb.clrWr  = 1'b1;
        default:   ;
      endcase
    end
    if (busRdEn) begin
      if (!upperZero) begin
        strb.rdSel = RD_ZERO;
      end else begin
        unique case (wordIdx)
          WIDX_DIR:  strb.rdSel = RD_DIR;
          WIDX_MASK: strb.rdSel = RD_MASK;
          WIDX_PIN:  strb.rdSel = RD_PIN;
          WIDX_SET:  strb.rdSel = RD_LATCH;
          default:   strb.rdSel = RD_ZERO;
        endcase
      end
    end
  end

  // R9: a write to an unlisted word index raises no write strobe
  always_comb begin
    if (busWrEn && upperZero && (wordIdx inside {3'd1, 3'd2, 3'd3})) begin
      a_r9_unlisted_no_strobe: assert ({strb.dirWr, strb.maskWr, strb.pinWr,
                                        strb.setWr, strb.clrWr} == 5'b0);
    end
  end

endmodule

// File: rtl/mgpio_sync.sv
module mgpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : gStage
      if (s == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[s] <= '0;
          else       stage[s] <= din;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[s] <= '0;
          else       stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/mgpio_datapath.sv
module mgpio_datapath #(
  parameter int PORT_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  mgpio_pkg::strobe_t  strb,
  input  logic [PORT_W-1:0]   wrData,
  input  logic [PORT_W-1:0]   padSync,
  output logic [PORT_W-1:0]   dirReg,
  output logic [PORT_W-1:0]   outLatch,
  output logic [PORT_W-1:0]   rdData
);
  import mgpio_pkg::*;

  logic [PORT_W-1:0] maskReg;
  logic [PORT_W-1:0] rdNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg  <= '0;
      maskReg <= '0;
    end else begin
      if (strb.dirWr)  dirReg  <= wrData;
      if (strb.maskWr) maskReg <= wrData;
    end
  end

  generate
    for (genvar i = 0; i < PORT_W; i++) begin : gBit
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          outLatch[i] <= 1'b0;
        end else if (!maskReg[i]) begin
          if (strb.pinWr)                   outLatch[i] <= wrData[i];
          else if (strb.setWr && wrData[i]) outLatch[i] <= 1'b1;
          else if (strb.clrWr && wrData[i]) outLatch[i] <= 1'b0;
        end
      end
    end
  endgenerate

  always_comb begin
    unique case (strb.rdSel)
      RD_DIR:   rdNext = dirReg;
      RD_MASK:  rdNext = maskReg;
      RD_PIN:   rdNext = padSync & ~maskReg;
      RD_LATCH: rdNext = outLatch;
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end

  // R5: masked latch bits never move on a latch-changing write
  a_r5_masked_bits_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pinWr || strb.setWr || strb.clrWr)
      |=> (((outLatch ^ $past(outLatch)) & $past(maskReg)) == '0));

  // R6: a set write only raises latch bits
  a_r6_set_only_raises: assert property (@(posedge clk) disable iff (!rstN)
    strb.setWr |=> (($past(outLatch) & ~outLatch) == '0));

  // R8: a clear write only lowers latch bits
  a_r8_clear_only_lowers: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrWr |=> ((outLatch & ~$past(outLatch)) == '0));

  // R4: masked bits of a pin read come back zero
  a_r4_masked_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSel == RD_PIN) |=> ((rdData & $past(maskReg)) == '0));

  // R11: no read strobe means zero read data next cycle
  a_r11_idle_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSel == RD_NONE) |=> (rdData == '0));

  // R3: mask only changes on a mask write
  a_r3_mask_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strb.maskWr |=> $stable(maskReg));

endmodule

// File: rtl/mgpio_port.sv
module mgpio_port #(
  parameter int PORT_W      = 32,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [PORT_W-1:0] busWrData,
  output logic [PORT_W-1:0] busRdData,
  input  logic [PORT_W-1:0] padIn,
  output logic [PORT_W-1:0] padOut,
  output logic [PORT_W-1:0] padOe
);
  import mgpio_pkg::*;

  strobe_t           strb;
  logic [PORT_W-1:0] padSync;
  logic [PORT_W-1:0] dirReg;
  logic [PORT_W-1:0] outLatch;

  mgpio_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .busAddr (busAddr),
    .strb    (strb)
  );

  mgpio_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .din  (padIn),
    .dout (padSync)
  );

  mgpio_datapath #(.PORT_W(PORT_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (busWrData),
    .padSync  (padSync),
    .dirReg   (dirReg),
    .outLatch (outLatch),
    .rdData   (busRdData)
  );

  assign padOe  = dirReg;
  assign padOut = outLatch;

endmodule

// File: tb/mgpio_port_test.sv
module mgpio_port_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [31:0] padIn = '0;
  logic [31:0] padOut;
  logic [31:0] padOe;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  mgpio_port uut (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busRdEn   (busRdEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .padIn     (padIn),
    .padOut    (padOut),
    .padOe     (padOe)
  );

  // behavioural reference model
  logic [31:0] mDir, mMask, mOut, mRd;
  logic [31:0] padQ[$];
  string       rdTag  = "R11";
  string       outTag = "R10";

  always @(posedge clk) begin
    if (!rstN) begin
      mDir = 0; mMask = 0; mOut = 0; mRd = 0;
      padQ = '{32'h0, 32'h0};
      rdTag = "R1"; outTag = "R1";
    end else begin
      logic [31:0] seen;
      seen = padQ[0];
      mRd = 0; rdTag = "R11";
      if (busRdEn) begin
        case (busAddr)
          3'd0: begin mRd = mDir;           rdTag = "R2"; end
          3'd4: begin mRd = mMask;          rdTag = "R3"; end
          3'd5: begin mRd = seen & ~mMask;  rdTag = "R4"; end
          3'd6: begin mRd = mOut;           rdTag = "R7"; end
          3'd7: begin mRd = 0;              rdTag = "R8"; end
          default: begin mRd = 0;           rdTag = "R9"; end
        endcase
      end
      outTag = "R10";
      if (busWrEn) begin
        case (busAddr)
          3'd0: mDir = busWrData;
          3'd5: begin mOut = (mOut & mMask) | (busWrData & ~mMask); outTag = "R5"; end
          3'd6: begin mOut = mOut | (busWrData & ~mMask);           outTag = "R6"; end
          3'd7: begin mOut = mOut & ~(busWrData & ~mMask);          outTag = "R8"; end
          3'd4: mMask = busWrData;
          default: outTag = "R9";
        endcase
      end
      padQ.push_back(padIn);
      void'(padQ.pop_front());
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    check(rdTag, busRdData, mRd);
    check("R2", padOe, mDir);
    check(outTag, padOut, mOut);
  endtask

  // one bus cycle: compare at the falling edge, then drive the next inputs
  task automatic cyc(bit wr, bit rd, logic [2:0] a, logic [31:0] d, logic [31:0] p);
    @(negedge clk);
    compareAll();
    busWrEn = wr; busRdEn = rd; busAddr = a; busWrData = d; padIn = p;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, padIn);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    padIn = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", padOe, 32'h0);
    check("R1", padOut, 32'h0);
    check("R1", busRdData, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", padOut, 32'h0);
    check("R1", padOe, 32'h0);

    // R2 direction, R3 mask read-back
    cyc(1, 0, 0, 32'hA5A5_0F0F, padIn);
    cyc(0, 1, 0, 0, padIn);
    cyc(1, 0, 4, 32'h0000_FFFF, padIn);
    cyc(0, 1, 4, 0, padIn);
    // R4 pin read with masking and direction independence
    cyc(0, 0, 0, 0, 32'h1234_5678);
    idle(2);
    cyc(0, 1, 5, 0, padIn);
    // R5 masked load, R7 latch read
    cyc(1, 0, 5, 32'hFFFF_FFFF, padIn);
    cyc(0, 1, 6, 0, padIn);
    // R6 set, R8 clear under mask
    cyc(1, 0, 4, 32'hF0F0_F0F0, padIn);
    cyc(1, 0, 7, 32'hFFFF_FFFF, padIn);
    cyc(1, 0, 6, 32'h0000_00FF, padIn);
    cyc(0, 1, 7, 0, padIn);
    // R9 unlisted words
    cyc(1, 1, 1, 32'hDEAD_BEEF, padIn);
    cyc(1, 1, 2, 32'hDEAD_BEEF, padIn);
    cyc(1, 1, 3, 32'hDEAD_BEEF, padIn);
    cyc(0, 1, 6, 0, padIn);
    // R11 read and write in the same cycle
    cyc(1, 1, 6, 32'hFFFF_FFFF, padIn);
    cyc(1, 1, 4, 32'h0, padIn);
    cyc(0, 1, 5, 0, 32'hCAFE_F00D);
    cyc(0, 1, 5, 0, padIn);
    cyc(0, 1, 5, 0, padIn);
    idle(2);

    // random traffic across all word indices
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d;
      d = $urandom;
      if (($urandom % 4) == 0) d = d & $urandom;
      cyc(1'($urandom % 2), 1'($urandom % 2), 3'($urandom % 8), d,
          (($urandom % 3) == 0) ? 32'($urandom) : padIn);
    end
    idle(3);
    @(negedge clk);
    compareAll();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule